// File: doc/BRIEF.md
# I2C Master Transaction Sequencer

This block runs one complete I2C read or write of a programmed length on top of a byte-level master engine that reports its progress as 8-bit status codes. The host supplies a device address, a flag selecting 10-bit addressing, a direction and a byte count, then pulses `go`. The sequencer asks the engine for a START condition. It sends one address byte for a 7-bit device or two for a 10-bit device. It then streams bytes either from a FIFO-style write source or onto a read strobe port, and it finishes with STOP. After each engine event it picks the next engine command by decoding the status code that came with the event.

The sequencer has six states. IDLE moves to WAIT_START on `go`. WAIT_START moves to WAIT_ADDR1 on a START or repeated-START status. WAIT_ADDR1 moves to WAIT_ADDR2 when the first address byte is acknowledged in 10-bit mode. It moves to WAIT_WR_ACK when a write byte goes out, and to WAIT_RD_DATA when a read phase begins. WAIT_WR_ACK loops on itself once per byte, and WAIT_RD_DATA loops on itself once per received byte. Every STOP, whether on success, no-device or error, returns the machine to IDLE. Each transfer ends with a `done` pulse that carries a result code. An unexpected status also requests a soft reset of the engine. A status event that arrives while the sequencer is IDLE is a leftover of an abandoned transfer. It is answered with STOP and does not signal `done`.

Top module: `i2c_xact_seq`

## Requirements
- R1: With 7-bit addressing, the first address byte on `eng_tx_data` is `{dev_addr[6:0], rd_not_wr}`. A read puts 1 in bit 0.
- R2: With 10-bit addressing, the first address byte is `8'hF0 | dev_addr[9:8]<<1 | rd_not_wr`. After status 0x18 (write) or 0x40 (read), the sequencer sends a second address byte equal to `dev_addr[7:0]`.
- R3: In the cycle after `go` is sampled while idle, `eng_cmd_vld` is 1 with `eng_cmd`=1 (START), and `busy` is 1. Status 0x08 or 0x10 gives a SEND command (`eng_cmd`=2) that carries the first address byte.
- R4: On a write, status 0x18 (7-bit mode), 0xD0 or 0x28 leads to one of two outcomes. If bytes remain, the sequencer sends the current `wr_data` byte (`eng_cmd`=2) and pulses `wr_pop` in the same cycle. Otherwise it sends STOP (`eng_cmd`=4) and pulses `done` with `result`=0.
- R5: If an abort is pending (`abort_req` latched while busy, or high in the same cycle as the event), a write ack leads to STOP only after at least one data byte has gone out. Before the first byte, the abort has no effect.
- R6: A read with `xfer_len`=0 answers the address ack 0x40 with STOP and `result`=0. This makes it usable as a device probe.
- R7: A read phase starts with a RESUME command (`eng_cmd`=3). Each status 0x50 gives one `rd_valid` pulse with `eng_rx_data` on `rd_data`, in receive order, followed by RESUME. `eng_ack_en` falls to 0 once one byte remains or an abort is pending. Status 0x58 delivers the last byte and sends STOP with `result`=0.
- R8: Status 0x20, 0x30 or 0x48 sends STOP and ends the transfer with `result`=1 (no device).
- R9: Any other status sends STOP, pulses `eng_srst` and ends the transfer with `result`=2 (controller error).
- R10: An engine event while idle (with no `go` in the same cycle) produces a STOP command but no `done`, and `busy` stays 0.
- R11: `go` sets `eng_int_en` and `eng_ack_en` to 1. Every STOP command clears `eng_int_en`, drops `busy` in the same cycle, and coincides with `done` unless the sequencer was idle.
- R12: A `go` pulse while busy is ignored and leaves the address, length and direction of the running transfer unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| go | input | 1 | Start a transfer (taken only when idle) |
| dev_addr | input | 10 | Device address (7-bit mode uses bits 6:0) |
| ten_bit | input | 1 | 1 selects 10-bit addressing |
| rd_not_wr | input | 1 | 1 = read, 0 = write |
| xfer_len | input | LEN_W | Number of data bytes |
| abort_req | input | 1 | Request an early end of the transfer |
| wr_data | input | 8 | Head byte of the write source |
| wr_pop | output | 1 | Head byte of the write source was consumed |
| rd_data | output | 8 | Received byte |
| rd_valid | output | 1 | `rd_data` is valid this cycle |
| busy | output | 1 | A transfer is in progress |
| done | output | 1 | Transfer finished this cycle |
| result | output | 2 | 0 ok, 1 no device, 2 controller error |
| eng_evt | input | 1 | Engine has a new status |
| eng_status | input | 8 | Engine status code |
| eng_rx_data | input | 8 | Byte received by the engine |
| eng_cmd_vld | output | 1 | Command to the engine is valid |
| eng_cmd | output | 3 | 1 START, 2 SEND byte, 3 RESUME, 4 STOP |
| eng_tx_data | output | 8 | Byte for a SEND command |
| eng_ack_en | output | 1 | Engine acknowledges received bytes |
| eng_int_en | output | 1 | Engine interrupt enable |
| eng_srst | output | 1 | Soft-reset request to the engine |

## Verification
An abort request and a write-ack status event can arrive in the same clock cycle, and the abort must still count for that event. The bench raises `abort_req` in the same cycle as `eng_evt` twice in one write. The first time is on the address ack, where no byte has gone out yet, so the expected outcome is a SEND of the first byte. The second time is on the following data ack, where the expected outcome is STOP with a good result even though bytes remain. A read test also pairs an abort with the first read-phase status and expects `eng_ack_en` to fall at once.

// File: rtl/i2cseq_pkg.sv
package i2cseq_pkg;
    localparam int BYTE_W = 8;

    typedef enum logic [2:0] {
        CMD_NONE   = 3'd0,
        CMD_START  = 3'd1,
        CMD_SEND   = 3'd2,
        CMD_RESUME = 3'd3,
        CMD_STOP   = 3'd4
    } cmd_e;

    typedef enum logic [1:0] {
        RES_OK    = 2'd0,
        RES_NODEV = 2'd1,
        RES_IOERR = 2'd2
    } res_e;

    typedef enum logic [2:0] {
        ST_IDLE, ST_WAIT_START, ST_WAIT_ADDR1, ST_WAIT_ADDR2,
        ST_WAIT_WR_ACK, ST_WAIT_RD_DATA
    } state_e;

    typedef enum logic [1:0] {
        TX_NONE, TX_ADDR1, TX_ADDR2, TX_DATA
    } txsel_e;

    // engine status codes
    localparam logic [7:0] SC_START      = 8'h08;
    localparam logic [7:0] SC_RESTART    = 8'h10;
    localparam logic [7:0] SC_WADDR_ACK  = 8'h18;
    localparam logic [7:0] SC_WADDR_NAK  = 8'h20;
    localparam logic [7:0] SC_WDATA_ACK  = 8'h28;
    localparam logic [7:0] SC_WDATA_NAK  = 8'h30;
    localparam logic [7:0] SC_RADDR_ACK  = 8'h40;
    localparam logic [7:0] SC_RADDR_NAK  = 8'h48;
    localparam logic [7:0] SC_RDATA_ACK  = 8'h50;
    localparam logic [7:0] SC_RDATA_NAK  = 8'h58;
    localparam logic [7:0] SC_WADDR2_ACK = 8'hD0;
    localparam logic [7:0] SC_RADDR2_ACK = 8'hE0;

    typedef struct packed {
        cmd_e   cmd;
        state_e nxt;
        txsel_e txs;
        logic   pop;
        logic   dec;
        logic   cap;
        logic   clr_ack;
        logic   fin;
        logic   srst;
        res_e   res;
    } decision_t;
endpackage

// File: rtl/i2cseq_addr.sv
module i2cseq_addr
    import i2cseq_pkg::*;
(
    input  logic [9:0]        addr,
    input  logic              ten,
    input  logic              rd,
    output logic [BYTE_W-1:0] first_byte,
    output logic [BYTE_W-1:0] second_byte
);
    always_comb begin
        if (ten) begin
            first_byte  = 8'hF0 | {5'd0, addr[9:8], rd};
            second_byte = addr[7:0];
        end else begin
            first_byte  = {addr[6:0], rd};
            second_byte = '0;
        end
    end
endmodule

// File: rtl/i2cseq_remain.sv
module i2cseq_remain #(
    parameter int LEN_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [LEN_W-1:0] load_val,
    input  logic             dec,
    output logic             is_zero,
    output logic             is_one,
    output logic             is_two
);
    localparam logic [LEN_W-1:0] ONE = LEN_W'(1);
    localparam logic [LEN_W-1:0] TWO = LEN_W'(2);

    logic [LEN_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (load)
            cnt_q <= load_val;
        else if (dec && cnt_q != '0)
            cnt_q <= cnt_q - ONE;
    end

    assign is_zero = (cnt_q == '0);
    assign is_one  = (cnt_q == ONE);
    assign is_two  = (cnt_q == TWO);
endmodule

// File: rtl/i2cseq_decide.sv
module i2cseq_decide
    import i2cseq_pkg::*;
(
    input  state_e      state,
    input  logic [7:0]  status,
    input  logic        ten,
    input  logic        rem_zero,
    input  logic        rem_one,
    input  logic        rem_two,
    input  logic        aborting,
    input  logic        sent_any,
    output decision_t   d
);
    function automatic decision_t stop_with(res_e r, logic f, logic s);
        decision_t t;
        t         = '0;
        t.cmd     = CMD_STOP;
        t.nxt     = ST_IDLE;
        t.txs     = TX_NONE;
        t.fin     = f;
        t.srst    = s;
        t.res     = r;
        return t;
    endfunction

    decision_t wr_path, rd_path;

    always_comb begin
        // write acknowledge handling
        if (rem_zero || (aborting && sent_any)) begin
            wr_path = stop_with(RES_OK, 1'b1, 1'b0);
        end else begin
            wr_path     = '0;
            wr_path.cmd = CMD_SEND;
            wr_path.nxt = ST_WAIT_WR_ACK;
            wr_path.txs = TX_DATA;
            wr_path.pop = 1'b1;
            wr_path.dec = 1'b1;
            wr_path.res = RES_OK;
        end
        // read address acknowledge handling
        if (rem_zero) begin
            rd_path = stop_with(RES_OK, 1'b1, 1'b0);
        end else begin
            rd_path         = '0;
            rd_path.cmd     = CMD_RESUME;
            rd_path.nxt     = ST_WAIT_RD_DATA;
            rd_path.txs     = TX_NONE;
            rd_path.clr_ack = rem_one || aborting;
            rd_path.res     = RES_OK;
        end
    end

    always_comb begin
        d = '0;
        if (state == ST_IDLE) begin
            d = stop_with(RES_OK, 1'b0, 1'b0);
        end else begin
            unique case (status)
                SC_START, SC_RESTART: begin
                    d.cmd = CMD_SEND;
                    d.nxt = ST_WAIT_ADDR1;
                    d.txs = TX_ADDR1;
                end
                SC_WADDR_ACK: begin
                    if (ten) begin
                        d.cmd = CMD_SEND;
                        d.nxt = ST_WAIT_ADDR2;
                        d.txs = TX_ADDR2;
                    end else begin
                        d = wr_path;
                    end
                end
                SC_WADDR2_ACK, SC_WDATA_ACK: d = wr_path;
                SC_RADDR_ACK: begin
                    if (ten) begin
                        d.cmd = CMD_SEND;
                        d.nxt = ST_WAIT_ADDR2;
                        d.txs = TX_ADDR2;
                    end else begin
                        d = rd_path;
                    end
                end
                SC_RADDR2_ACK: d = rd_path;
                SC_RDATA_ACK: begin
                    d.cmd     = CMD_RESUME;
                    d.nxt     = ST_WAIT_RD_DATA;
                    d.txs     = TX_NONE;
                    d.cap     = 1'b1;
                    d.dec     = 1'b1;
                    d.clr_ack = rem_two || aborting;
                end
                SC_RDATA_NAK: begin
                    d     = stop_with(RES_OK, 1'b1, 1'b0);
                    d.cap = 1'b1;
                end
                SC_WADDR_NAK, SC_WDATA_NAK, SC_RADDR_NAK:
                    d = stop_with(RES_NODEV, 1'b1, 1'b0);
                default:
                    d = stop_with(RES_IOERR, 1'b1, 1'b1);
            endcase
        end
    end
endmodule

// File: rtl/i2c_xact_seq.sv
module i2c_xact_seq
    import i2cseq_pkg::*;
#(
    parameter int LEN_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             go,
    input  logic [9:0]       dev_addr,
    input  logic             ten_bit,
    input  logic             rd_not_wr,
    input  logic [LEN_W-1:0] xfer_len,
    input  logic             abort_req,
    input  logic [7:0]       wr_data,
    output logic             wr_pop,
    output logic [7:0]       rd_data,
    output logic             rd_valid,
    output logic             busy,
    output logic             done,
    output logic [1:0]       result,
    input  logic             eng_evt,
    input  logic [7:0]       eng_status,
    input  logic [7:0]       eng_rx_data,
    output logic             eng_cmd_vld,
    output logic [2:0]       eng_cmd,
    output logic [7:0]       eng_tx_data,
    output logic             eng_ack_en,
    output logic             eng_int_en,
    output logic             eng_srst
);
    state_e            state_q, state_d;
    decision_t         dcs;
    logic [BYTE_W-1:0] a1_in, a2_in, a1_q, a2_q;
    logic              ten_q, abort_q, sent_q;
    logic              rem_zero, rem_one, rem_two;
    logic              start_now, evt_now, eff_abort;
    cmd_e              cmd_q;
    res_e              res_q;

    assign start_now = (state_q == ST_IDLE) && go;
    assign evt_now   = eng_evt && !start_now;
    assign eff_abort = abort_q || abort_req;

    i2cseq_addr u_addr (
        .addr        (dev_addr),
        .ten         (ten_bit),
        .rd          (rd_not_wr),
        .first_byte  (a1_in),
        .second_byte (a2_in)
    );

    i2cseq_remain #(.LEN_W(LEN_W)) u_remain (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (start_now),
        .load_val (xfer_len),
        .dec      (evt_now && dcs.dec),
        .is_zero  (rem_zero),
        .is_one   (rem_one),
        .is_two   (rem_two)
    );

    i2cseq_decide u_decide (
        .state    (state_q),
        .status   (eng_status),
        .ten      (ten_q),
        .rem_zero (rem_zero),
        .rem_one  (rem_one),
        .rem_two  (rem_two),
        .aborting (eff_abort),
        .sent_any (sent_q),
        .d        (dcs)
    );

    always_comb begin
        state_d = state_q;
        if (start_now)
            state_d = ST_WAIT_START;
        else if (evt_now)
            state_d = dcs.nxt;
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    // outputs and transfer context
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmd_q       <= CMD_NONE;
            eng_cmd_vld <= 1'b0;
            eng_tx_data <= '0;
            eng_ack_en  <= 1'b0;
            eng_int_en  <= 1'b0;
            eng_srst    <= 1'b0;
            wr_pop      <= 1'b0;
            rd_data     <= '0;
            rd_valid    <= 1'b0;
            done        <= 1'b0;
            res_q       <= RES_OK;
            a1_q        <= '0;
            a2_q        <= '0;
            ten_q       <= 1'b0;
            abort_q     <= 1'b0;
            sent_q      <= 1'b0;
        end else begin
            eng_cmd_vld <= 1'b0;
            cmd_q       <= CMD_NONE;
            eng_srst    <= 1'b0;
            wr_pop      <= 1'b0;
            rd_valid    <= 1'b0;
            done        <= 1'b0;
            if (start_now) begin
                eng_cmd_vld <= 1'b1;
                cmd_q       <= CMD_START;
                eng_ack_en  <= 1'b1;
                eng_int_en  <= 1'b1;
                a1_q        <= a1_in;
                a2_q        <= a2_in;
                ten_q       <= ten_bit;
                abort_q     <= 1'b0;
                sent_q      <= 1'b0;
            end else begin
                if (busy && abort_req)
                    abort_q <= 1'b1;
                if (evt_now) begin
                    eng_cmd_vld <= 1'b1;
                    cmd_q       <= dcs.cmd;
                    unique case (dcs.txs)
                        TX_ADDR1: eng_tx_data <= a1_q;
                        TX_ADDR2: eng_tx_data <= a2_q;
                        TX_DATA:  eng_tx_data <= wr_data;
                        default:  eng_tx_data <= eng_tx_data;
                    endcase
                    if (dcs.pop) begin
                        wr_pop <= 1'b1;
                        sent_q <= 1'b1;
                    end
                    if (dcs.cap) begin
                        rd_data  <= eng_rx_data;
                        rd_valid <= 1'b1;
                    end
                    if (dcs.clr_ack)
                        eng_ack_en <= 1'b0;
                    if (dcs.cmd == CMD_STOP)
                        eng_int_en <= 1'b0;
                    if (dcs.fin) begin
                        done  <= 1'b1;
                        res_q <= dcs.res;
                    end
                    eng_srst <= dcs.srst;
                end
            end
        end
    end

    assign busy    = (state_q != ST_IDLE);
    assign eng_cmd = cmd_q;
    assign result  = res_q;
endmodule

// File: rtl/i2c_xact_seq_checker.sv
module i2c_xact_seq_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       go,
    input logic       busy,
    input logic       done,
    input logic [1:0] result,
    input logic       eng_evt,
    input logic       eng_cmd_vld,
    input logic [2:0] eng_cmd,
    input logic       eng_int_en,
    input logic       eng_srst,
    input logic       wr_pop
);
    AST_START_AFTER_GO: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && go) |=> (eng_cmd_vld && eng_cmd == 3'd1 && busy)); // R3
    AST_POP_WITH_SEND: assert property (@(posedge clk) disable iff (!rst_n)
        wr_pop |-> (eng_cmd_vld && eng_cmd == 3'd2)); // R4
    AST_SRST_IS_ERROR: assert property (@(posedge clk) disable iff (!rst_n)
        eng_srst |-> (done && result == 2'd2 && eng_cmd == 3'd4)); // R9
    AST_IDLE_EVT_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !go && eng_evt) |=> (eng_cmd_vld && eng_cmd == 3'd4 && !done && !busy)); // R10
    AST_STOP_DROPS_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_cmd_vld && eng_cmd == 3'd4) |-> (!eng_int_en && !busy)); // R11
    AST_DONE_ON_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (eng_cmd_vld && eng_cmd == 3'd4)); // R11
    AST_GO_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && go) |=> !(eng_cmd_vld && eng_cmd == 3'd1)); // R12
endmodule

bind i2c_xact_seq i2c_xact_seq_checker u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .go          (go),
    .busy        (busy),
    .done        (done),
    .result      (result),
    .eng_evt     (eng_evt),
    .eng_cmd_vld (eng_cmd_vld),
    .eng_cmd     (eng_cmd),
    .eng_int_en  (eng_int_en),
    .eng_srst    (eng_srst),
    .wr_pop      (wr_pop)
);

// File: tb/i2c_xact_seq_bench.sv
module i2c_xact_seq_bench;
    localparam int LEN_W = 8;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             go = 1'b0;
    logic [9:0]       dev_addr = '0;
    logic             ten_bit = 1'b0;
    logic             rd_not_wr = 1'b0;
    logic [LEN_W-1:0] xfer_len = '0;
    logic             abort_req = 1'b0;
    logic [7:0]       wr_data = '0;
    logic             wr_pop;
    logic [7:0]       rd_data;
    logic             rd_valid;
    logic             busy;
    logic             done;
    logic [1:0]       result;
    logic             eng_evt = 1'b0;
    logic [7:0]       eng_status = '0;
    logic [7:0]       eng_rx_data = '0;
    logic             eng_cmd_vld;
    logic [2:0]       eng_cmd;
    logic [7:0]       eng_tx_data;
    logic             eng_ack_en;
    logic             eng_int_en;
    logic             eng_srst;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    logic [7:0] wbuf [0:7];
    int         widx = 0;

    // captured at a command
    logic [2:0] c_cmd;
    logic [7:0] c_tx, c_rd;
    logic       c_done, c_busy, c_int, c_ack, c_pop, c_rv, c_srst;
    logic [1:0] c_res;

    i2c_xact_seq #(.LEN_W(LEN_W)) u_i2c_xact_seq (
        .clk(clk), .rst_n(rst_n), .go(go), .dev_addr(dev_addr),
        .ten_bit(ten_bit), .rd_not_wr(rd_not_wr), .xfer_len(xfer_len),
        .abort_req(abort_req), .wr_data(wr_data), .wr_pop(wr_pop),
        .rd_data(rd_data), .rd_valid(rd_valid), .busy(busy), .done(done),
        .result(result), .eng_evt(eng_evt), .eng_status(eng_status),
        .eng_rx_data(eng_rx_data), .eng_cmd_vld(eng_cmd_vld),
        .eng_cmd(eng_cmd), .eng_tx_data(eng_tx_data),
        .eng_ack_en(eng_ack_en), .eng_int_en(eng_int_en),
        .eng_srst(eng_srst)
    );

    always #2 clk = ~clk;

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin : watchdog
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 100000) begin
                checks++;
                errors++;
                $display("FAIL watchdog actual=%0d expected=done", cycles);
                finish_run();
            end
        end
    end

    // wait (at negedges) for the next engine command and capture outputs
    task automatic wait_cmd(string req);
        int n = 0;
        while (!eng_cmd_vld && n < 40) begin
            @(negedge clk);
            n++;
        end
        checks++;
        if (!eng_cmd_vld) begin
            errors++;
            $display("FAIL %s actual=no-command expected=command", req);
        end
        c_cmd = eng_cmd;  c_tx = eng_tx_data; c_done = done; c_res = result;
        c_busy = busy;    c_int = eng_int_en; c_ack = eng_ack_en;
        c_pop = wr_pop;   c_rv = rd_valid;    c_rd = rd_data; c_srst = eng_srst;
        if (wr_pop) begin
            widx++;
            wr_data = wbuf[widx % 8];
        end
    endtask

    task automatic respond(logic [7:0] st, logic [7:0] rx, logic ab);
        eng_evt = 1'b1; eng_status = st; eng_rx_data = rx; abort_req = ab;
        @(negedge clk);
        eng_evt = 1'b0; abort_req = 1'b0;
    endtask

    task automatic start_xfer(logic [9:0] a, logic ten, logic rd, int len);
        dev_addr = a; ten_bit = ten; rd_not_wr = rd; xfer_len = LEN_W'(len);
        widx = 0; wr_data = wbuf[0];
        go = 1'b1;
        @(negedge clk);
        go = 1'b0;
        wait_cmd("R3");
        check("R3 start cmd", c_cmd, 3'd1);
        check("R3 busy", c_busy, 1'b1);
        check("R11 int_en at go", c_int, 1'b1);
    endtask

    task automatic expect_stop(string req, logic [1:0] res);
        check({req, " stop"}, c_cmd, 3'd4);
        check({req, " done"}, c_done, 1'b1);
        check({req, " result"}, c_res, res);
        check("R11 int_en cleared", c_int, 1'b0);
        check("R11 busy low", c_busy, 1'b0);
    endtask

    task automatic t_reset();
        check("reset busy", busy, 1'b0);
        check("reset cmd_vld", eng_cmd_vld, 1'b0);
        check("reset done", done, 1'b0);
        check("reset int_en", eng_int_en, 1'b0);
    endtask

    task automatic t_write7();
        wbuf[0] = 8'hA5; wbuf[1] = 8'h3C;
        start_xfer(10'h05A, 1'b0, 1'b0, 2);
        respond(8'h08, 8'h00, 1'b0); wait_cmd("R1");
        check("R3 send on start", c_cmd, 3'd2);
        check("R1 addr byte", c_tx, 8'hB4);
        respond(8'h18, 8'h00, 1'b0); wait_cmd("R4");
        check("R4 data0", c_tx, 8'hA5);
        check("R4 pop0", c_pop, 1'b1);
        respond(8'h28, 8'h00, 1'b0); wait_cmd("R4");
        check("R4 data1", c_tx, 8'h3C);
        respond(8'h28, 8'h00, 1'b0); wait_cmd("R4");
        expect_stop("R4 end", 2'd0);
        check("R4 no pop on stop", c_pop, 1'b0);
    endtask

    task automatic t_write10();
        wbuf[0] = 8'h77;
        start_xfer(10'h3C1, 1'b1, 1'b0, 1);
        respond(8'h10, 8'h00, 1'b0); wait_cmd("R2");
        check("R2 first byte wr", c_tx, 8'hF6);
        respond(8'h18, 8'h00, 1'b0); wait_cmd("R2");
        check("R2 second byte", c_tx, 8'hC1);
        respond(8'hD0, 8'h00, 1'b0); wait_cmd("R4");
        check("R4 data after D0", c_tx, 8'h77);
        respond(8'h28, 8'h00, 1'b0); wait_cmd("R4");
        expect_stop("R4 10bit end", 2'd0);
    endtask

    task automatic t_read10();
        start_xfer(10'h2C7, 1'b1, 1'b1, 3);
        respond(8'h08, 8'h00, 1'b0); wait_cmd("R2");
        check("R2 first byte rd", c_tx, 8'hF5);
        respond(8'h40, 8'h00, 1'b0); wait_cmd("R2");
        check("R2 second byte rd", c_tx, 8'hC7);
        respond(8'hE0, 8'h00, 1'b0); wait_cmd("R7");
        check("R7 resume", c_cmd, 3'd3);
        check("R7 ack on 3 left", c_ack, 1'b1);
        respond(8'h50, 8'h11, 1'b0); wait_cmd("R7");
        check("R7 rv0", c_rv, 1'b1);
        check("R7 rd0", c_rd, 8'h11);
        check("R7 ack on 2 left", c_ack, 1'b1);
        respond(8'h50, 8'h22, 1'b0); wait_cmd("R7");
        check("R7 rd1", c_rd, 8'h22);
        check("R7 ack off on last", c_ack, 1'b0);
        respond(8'h58, 8'h33, 1'b0); wait_cmd("R7");
        check("R7 rd2", c_rd, 8'h33);
        check("R7 rv2", c_rv, 1'b1);
        expect_stop("R7 end", 2'd0);
    endtask

    task automatic t_probe();
        start_xfer(10'h050, 1'b0, 1'b1, 0);
        respond(8'h08, 8'h00, 1'b0); wait_cmd("R1");
        check("R1 read addr byte", c_tx, 8'hA1);
        respond(8'h40, 8'h00, 1'b0); wait_cmd("R6");
        expect_stop("R6 probe", 2'd0);
    endtask

    task automatic t_nodev();
        start_xfer(10'h012, 1'b0, 1'b0, 1);
        respond(8'h08, 8'h00, 1'b0); wait_cmd("R8");
        respond(8'h20, 8'h00, 1'b0); wait_cmd("R8");
        expect_stop("R8 0x20", 2'd1);
        start_xfer(10'h012, 1'b0, 1'b1, 2);
        respond(8'h08, 8'h00, 1'b0); wait_cmd("R8");
        respond(8'h48, 8'h00, 1'b0); wait_cmd("R8");
        expect_stop("R8 0x48", 2'd1);
        wbuf[0] = 8'h01; wbuf[1] = 8'h02;
        start_xfer(10'h012, 1'b0, 1'b0, 2);
        respond(8'h08, 8'h00, 1'b0); wait_cmd("R8");
        respond(8'h18, 8'h00, 1'b0); wait_cmd("R8");
        respond(8'h30, 8'h00, 1'b0); wait_cmd("R8");
        expect_stop("R8 0x30", 2'd1);
    endtask

    task automatic t_error();
        start_xfer(10'h033, 1'b0, 1'b0, 1);
        respond(8'h38, 8'h00, 1'b0); wait_cmd("R9");
        expect_stop("R9 bad status", 2'd2);
        check("R9 soft reset", c_srst, 1'b1);
        start_xfer(10'h033, 1'b0, 1'b1, 1);
        respond(8'h08, 8'h00, 1'b0); wait_cmd("R9");
        respond(8'hE8, 8'h00, 1'b0); wait_cmd("R9");
        expect_stop("R9 E8", 2'd2);
        check("R9 soft reset E8", c_srst, 1'b1);
    endtask

    task automatic t_idle_evt();
        respond(8'h28, 8'h00, 1'b0); wait_cmd("R10");
        check("R10 stop", c_cmd, 3'd4);
        check("R10 no done", c_done, 1'b0);
        check("R10 busy low", c_busy, 1'b0);
        check("R10 srst low", c_srst, 1'b0);
        @(negedge clk);
        check("R10 still idle", busy, 1'b0);
    endtask

    task automatic t_abort_write();
        wbuf[0] = 8'h5E; wbuf[1] = 8'h6F; wbuf[2] = 8'h70;
        start_xfer(10'h021, 1'b0, 1'b0, 3);
        respond(8'h08, 8'h00, 1'b0); wait_cmd("R5");
        respond(8'h18, 8'h00, 1'b1); wait_cmd("R5");
        check("R5 abort before byte ignored", c_cmd, 3'd2);
        check("R5 first byte sent", c_tx, 8'h5E);
        respond(8'h28, 8'h00, 1'b1); wait_cmd("R5");
        expect_stop("R5 abort stop", 2'd0);
    endtask

    task automatic t_abort_read();
        start_xfer(10'h044, 1'b0, 1'b1, 4);
        respond(8'h08, 8'h00, 1'b0); wait_cmd("R7");
        respond(8'h40, 8'h00, 1'b1); wait_cmd("R7");
        check("R7 abort resume", c_cmd, 3'd3);
        check("R7 abort clears ack", c_ack, 1'b0);
        respond(8'h58, 8'h9A, 1'b0); wait_cmd("R7");
        check("R7 abort byte", c_rd, 8'h9A);
        expect_stop("R7 abort end", 2'd0);
    endtask

    task automatic t_go_busy();
        wbuf[0] = 8'h42;
        start_xfer(10'h066, 1'b0, 1'b0, 1);
        dev_addr = 10'h011; rd_not_wr = 1'b1; xfer_len = '0;
        go = 1'b1;
        @(negedge clk);
        go = 1'b0;
        check("R12 no extra cmd", eng_cmd_vld, 1'b0);
        respond(8'h08, 8'h00, 1'b0); wait_cmd("R12");
        check("R12 addr kept", c_tx, 8'hCC);
        respond(8'h18, 8'h00, 1'b0); wait_cmd("R12");
        check("R12 len kept", c_cmd, 3'd2);
        check("R12 data", c_tx, 8'h42);
        respond(8'h28, 8'h00, 1'b0); wait_cmd("R12");
        expect_stop("R12 end", 2'd0);
    endtask

    initial begin
        for (int i = 0; i < 8; i++) wbuf[i] = 8'(i);
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_write7();
        t_write10();
        t_read10();
        t_probe();
        t_nodev();
        t_error();
        t_idle_evt();
        t_abort_write();
        t_abort_read();
        t_go_busy();
        repeat (4) @(negedge clk);
        finish_run();
    end
endmodule